// File: doc/BRIEF.md
# Cascadable Serial Result Readout

This block is the digital output stage of an 18-bit sampling converter that works as a serial slave. A behavioural conversion model hands it a parallel result together with a busy flag. When busy drops, the word is copied into a shift register in one step. An external host then clocks the word out, most significant bit first, using a serial clock that it may stop and restart between bursts. The host selects the device with an active-low chip select and an active-low read strobe.

A serial input feeds the low end of the shift register, so several devices can be chained. Each device takes in its input on the serial-clock edge opposite to the one that advances its output. The first bit of an upstream device therefore follows the last local bit with no idle slot. All devices in a chain share one conversion start and load their results at the same moment.

The host pins and the busy flag arrive through a register synchronizer of parameter depth into a fast system clock. Edges of the serial clock are detected in that domain.

Top module: `chain_readout`

## Requirements
- R1: After reset, `sdout_oe` and `sdout` are both 0.
- R2: A high-to-low transition of `busy` copies `result` into the shift register, and its bit 17 is the first bit presented on `sdout`, before any serial clock pulse.
- R3: `sdout_oe` is 1 only while `cs_n` is 0, `rd_n` is 0 and `busy` is 0. Otherwise it is 0 and `sdout` is held at 0.
- R4: While enabled, each falling edge of `sclk` advances `sdout` to the next lower bit. The value is stable from that falling edge through the following rising edge, so the host may sample on either edge. The word goes out over 18 pulses, from bit 17 to bit 0.
- R5: While enabled, `sdin` is captured on each rising edge of `sclk` and enters the low end of the shift register on the next falling edge. The value captured at pulse k therefore appears on `sdout` at pulse k+18.
- R6: Serial clock edges that occur while `cs_n` or `rd_n` is 1 are ignored. The bit position is held and reading resumes at the same bit.
- R7: When a load from R2 and a falling `sclk` edge are seen in the same cycle, the load wins and no shift is applied. The next read starts at bit 17 of the new result.
- R8: In a chain of two devices, where the upstream `sdout` drives the downstream `sdin` and both share `busy`, `cs_n`, `rd_n` and `sclk`, 36 pulses return the downstream word and then the upstream word, each most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | Conversion in progress; its falling edge loads `result` |
| result | input | WORD_W | Parallel conversion result, held stable while `busy` is low |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| sclk | input | 1 | Host serial clock, may stop between bursts |
| sdin | input | 1 | Cascade input from the upstream device |
| sdout | output | 1 | Serial data, most significant bit first |
| sdout_oe | output | 1 | Output drive enable, standing in for a tri-state pin |

## Verification
Two events can fall in the same system cycle: the load triggered by the end of a conversion and a shift triggered by a falling serial clock. The bench provokes this by holding `sclk` high while `busy` is high, then dropping both in the same instant. Because every host-side input passes through the same synchronizer, the two edges are detected together. The scoreboard then expects the next 36 sampled bits to be both new results, each complete from bit 17, with no bit lost to the discarded shift.

// File: rtl/chain_readout_pkg.sv
`timescale 1ns/1ps
package chain_readout_pkg;

    // Host- and converter-side pins that cross into the system clock domain
    typedef struct packed {
        logic sclk;
        logic sdin;
        logic busy;
        logic cs_n;
        logic rd_n;
    } host_pins_t;

    localparam int HOST_PINS_W = $bits(host_pins_t);

    // Value the synchronizer holds in reset: deselected, converting, clock low
    localparam host_pins_t HOST_PINS_IDLE = '{
        sclk : 1'b0,
        sdin : 1'b0,
        busy : 1'b1,
        cs_n : 1'b1,
        rd_n : 1'b1
    };

    // Edge-detector history
    typedef struct packed {
        logic sclk_p;
        logic busy_p;
    } ctrl_state_t;

endpackage

// File: rtl/cr_sync.sv
`timescale 1ns/1ps
module cr_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/cr_ctrl.sv
`timescale 1ns/1ps
module cr_ctrl
    import chain_readout_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  host_pins_t pins_s,
    output logic       load,
    output logic       shift,
    output logic       capture,
    output logic       en
);

    ctrl_state_t st_d;
    ctrl_state_t st_q;
    logic        sclk_rise;
    logic        sclk_fall;
    logic        busy_fall;

    always_comb begin
        st_d.sclk_p = pins_s.sclk;
        st_d.busy_p = pins_s.busy;

        sclk_rise = pins_s.sclk & ~st_q.sclk_p;
        sclk_fall = ~pins_s.sclk & st_q.sclk_p;
        busy_fall = ~pins_s.busy & st_q.busy_p;

        en      = ~pins_s.cs_n & ~pins_s.rd_n & ~pins_s.busy;
        load    = busy_fall;
        // a fresh result takes priority over a coincident shift
        shift   = sclk_fall & en & ~busy_fall;
        capture = sclk_rise & en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sclk_p <= 1'b0;
            st_q.busy_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pins_s.busy |-> (!shift && !capture));

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !shift);

    assert_deselect_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_s.cs_n || pins_s.rd_n) |-> (!shift && !capture));

endmodule

// File: rtl/cr_shifter.sv
`timescale 1ns/1ps
module cr_shifter #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         capture,
    input  logic [W-1:0] result,
    input  logic         sdin_s,
    output logic         msb
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         cap;
    } shift_state_t;

    shift_state_t st_d;
    shift_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.cap = sdin_s;
        end
        if (load) begin
            st_d.word = result;
        end else if (shift) begin
            st_d.word = {st_q.word[W-2:0], st_q.cap};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msb = st_q.word[W-1];

    assert_load_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.word == $past(result)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(st_q.word));

    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (st_q.word[W-1] == $past(st_q.word[W-2])));

    assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (st_q.word[0] == $past(st_q.cap)));

endmodule

// File: rtl/chain_readout.sv
`timescale 1ns/1ps
module chain_readout
    import chain_readout_pkg::*;
#(
    parameter int WORD_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [WORD_W-1:0] result,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic              sdout,
    output logic              sdout_oe
);

    host_pins_t             pins_raw;
    logic [HOST_PINS_W-1:0] pins_sync;
    host_pins_t             pins_s;
    logic                   load;
    logic                   shift;
    logic                   capture;
    logic                   en;
    logic                   msb;

    always_comb begin
        pins_raw.sclk = sclk;
        pins_raw.sdin = sdin;
        pins_raw.busy = busy;
        pins_raw.cs_n = cs_n;
        pins_raw.rd_n = rd_n;
    end

    // one synchronizer for every pin keeps sclk and sdin edge-aligned
    cr_sync #(
        .WIDTH   (HOST_PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (HOST_PINS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_sync)
    );

    assign pins_s = host_pins_t'(pins_sync);

    cr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_s  (pins_s),
        .load    (load),
        .shift   (shift),
        .capture (capture),
        .en      (en)
    );

    cr_shifter #(
        .W (WORD_W)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (shift),
        .capture (capture),
        .result  (result),
        .sdin_s  (pins_s.sdin),
        .msb     (msb)
    );

    assign sdout_oe = en;
    assign sdout    = en & msb;

    assert_quiet_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sdout_oe |-> !sdout);

    assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (msb == $past(result[WORD_W-1])));

endmodule

// File: tb/chain_readout_bench.sv
`timescale 1ns/1ps
module chain_readout_bench;

    localparam int W    = 18;
    localparam int HALF = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         busy = 1'b1;
    logic         cs_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         sclk = 1'b0;
    logic         ext_sdin = 1'b1;
    logic [W-1:0] res_dn = '0;
    logic [W-1:0] res_up = '0;
    logic         up_sdout, up_oe, dn_sdout, dn_oe;

    int    checks = 0;
    int    errors = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    chain_readout u_chain_readout (
        .clk(clk), .rst_n(rst_n), .busy(busy), .result(res_dn),
        .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk), .sdin(up_sdout),
        .sdout(dn_sdout), .sdout_oe(dn_oe)
    );

    chain_readout u_up (
        .clk(clk), .rst_n(rst_n), .busy(busy), .result(res_up),
        .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk), .sdin(ext_sdin),
        .sdout(up_sdout), .sdout_oe(up_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_word(input logic [W-1:0] w, input string req);
        for (int i = W - 1; i >= 0; i--) begin
            exp_q.push_back(w[i]);
            tag_q.push_back(req);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b0;
            wait_cyc(HALF);
        end
    endtask

    task automatic convert(input logic [W-1:0] dn, input logic [W-1:0] up);
        busy   = 1'b1;
        res_dn = dn;
        res_up = up;
        wait_cyc(5);
        busy = 1'b0;
        wait_cyc(6);
    endtask

    // monitor: the host samples on each enabled rising edge of sclk
    always @(posedge sclk) begin
        if (!cs_n && !rd_n && !busy) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 extra pulse", int'(dn_sdout), -1);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(dn_sdout == e, t, int'(dn_sdout), int'(e));
                chk(dn_oe == 1'b1, "R3 oe during read", int'(dn_oe), 1);
            end
        end
    end

    initial begin
        #400000;
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(4);
        chk(dn_oe == 1'b0, "R1 oe after reset", int'(dn_oe), 0);
        chk(dn_sdout == 1'b0, "R1 sdout after reset", int'(dn_sdout), 0);
        rst_n = 1'b1;
        wait_cyc(4);

        // R8 chain read, plus R5 fill from the far end
        convert(18'h2B4C7, 18'h1F0F3);
        chk(dn_oe == 1'b0, "R3 deselected", int'(dn_oe), 0);
        cs_n = 1'b0; rd_n = 1'b0;
        wait_cyc(4);
        chk(dn_oe == 1'b1, "R3 selected", int'(dn_oe), 1);
        chk(dn_sdout == 1'b1, "R2 msb before pulses", int'(dn_sdout), 1);
        push_word(18'h2B4C7, "R4 local word");
        push_word(18'h1F0F3, "R8 upstream word");
        exp_q.push_back(1'b1); tag_q.push_back("R5 far fill");
        exp_q.push_back(1'b1); tag_q.push_back("R5 far fill");
        pulses(38);
        rd_n = 1'b1;
        wait_cyc(4);
        chk(dn_oe == 1'b0, "R3 read strobe high", int'(dn_oe), 0);
        cs_n = 1'b1;
        wait_cyc(4);

        // R6 pauses on cs_n and then on rd_n
        convert(18'h0C35A, 18'h3A5C1);
        cs_n = 1'b0; rd_n = 1'b0;
        wait_cyc(4);
        push_word(18'h0C35A, "R6 local resume");
        push_word(18'h3A5C1, "R6 upstream resume");
        pulses(7);
        cs_n = 1'b1;
        wait_cyc(4);
        chk(dn_oe == 1'b0, "R6 paused by cs_n", int'(dn_oe), 0);
        pulses(5);
        cs_n = 1'b0;
        wait_cyc(4);
        pulses(18);
        rd_n = 1'b1;
        wait_cyc(4);
        pulses(4);
        rd_n = 1'b0;
        wait_cyc(4);
        pulses(11);
        chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

        // R7 load and shift edge in the same cycle
        busy   = 1'b1;
        res_dn = 18'h3C00F;
        res_up = 18'h05A96;
        wait_cyc(5);
        chk(dn_oe == 1'b0, "R3 busy high", int'(dn_oe), 0);
        sclk = 1'b1;
        wait_cyc(HALF);
        busy = 1'b0;
        sclk = 1'b0;
        wait_cyc(6);
        chk(dn_sdout == 1'b1, "R7 msb kept", int'(dn_sdout), 1);
        push_word(18'h3C00F, "R7 local after collision");
        push_word(18'h05A96, "R7 upstream after collision");
        pulses(36);

        // R8 extreme patterns
        convert(18'h3FFFF, 18'h00001);
        wait_cyc(2);
        push_word(18'h3FFFF, "R8 ones word");
        push_word(18'h00001, "R8 lsb-only word");
        pulses(36);

        chk(exp_q.size() == 0, "R8 all bits seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule